// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block decides which interrupt the processor services next. It receives a reset request, a software-interrupt request and six hardware sources: an external interrupt pin, timer compare channel 0, timer compare channel 1, timer overflow, keyboard and analog conversion done. Each hardware source arrives as a pending flag with its own local control bit. A global mask bit, which the block holds, blocks all six hardware sources. It does not block the software interrupt or reset.

The block arbitrates only when the processor signals an instruction boundary. The winning request is registered as a vector address together with the return address to push. Both values stay on the outputs until the processor acknowledges. A reset request bypasses the boundary rule and overrides anything held. The block also presents the raw hardware flags as a sparse 16-bit status word.

Top module: `irqv_top`

## Requirements
- R1: A reset request is taken on the next clock edge even without a boundary and even while another interrupt is held. It presents vector 0xFFFE with return address 0x0000 and sets the global mask.
- R2: When several requests are active, the order from winning to losing is: reset, software, pin (flag bit 0), channel 0 (bit 1), channel 1 (bit 2), overflow (bit 3), keyboard (bit 4), conversion (bit 5).
- R3: Vectors are 0xFFFC for software, 0xFFFA for pin, 0xFFF6 for channel 0, 0xFFF4 for channel 1, 0xFFF2 for overflow, 0xFFE0 for keyboard and 0xFFDE for conversion.
- R4: While the global mask is 1, hardware requests are not taken, but a software request still is.
- R5: The return address is the sampled pc for a software interrupt and pc minus one for a hardware interrupt.
- R6: Local control bits 0 and 4 disable their source when 1. Bits 1, 2, 3 and 5 enable their source when 1.
- R7: Arbitration occurs only in a cycle with `boundary` high and nothing held. Vector and return address stay constant until `ack`, and changes to pc or to the requests in the meantime have no effect.
- R8: Acknowledging any non-reset interrupt sets the global mask. A `cli` pulse clears it.
- R9: The status word carries flag bits 0,1,2,3,4,5 at positions 1,3,4,5,14,15. All other positions read 0.
- R10: A software request pulse is remembered until it is serviced. A lower-priority request that loses remains pending and is taken at a later boundary.
- R11: After synchronous reset (`rst_n` low), nothing is held and the global mask is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reset_req | input | 1 | Reset interrupt request |
| swi_req | input | 1 | Software interrupt request pulse |
| hw_flag | input | 6 | Hardware pending flags |
| hw_ctrl | input | 6 | Local control bits, per-bit polarity |
| cli | input | 1 | Clear global mask |
| boundary | input | 1 | Instruction boundary strobe |
| pc | input | 16 | Current program counter |
| ack | input | 1 | Processor has taken the held vector |
| take_valid | output | 1 | An interrupt is held |
| vector | output | 16 | Held vector address |
| ret_addr | output | 16 | Held return address |
| i_mask | output | 1 | Global mask state |
| status | output | 16 | Sparse status word |

## Verification
The hardest case to reach is a reset request that lands while a hardware vector is still held and unacknowledged. The bench reaches it by turning off its automatic acknowledge, letting a pin interrupt win a boundary, and then pulsing the reset request. The full priority chain is covered by raising all six flags together with a software pulse. Between boundaries, the bench withdraws one flag at a time and clears the mask.

// File: rtl/irqv_pkg.sv
// Package irqv_pkg: shared constants for the interrupt vector controller.
// Source index 0 is reset, 1 is software, 2.. are hardware sources in
// falling priority. Assumes 16-bit addresses.
package irqv_pkg;
    localparam int NUM_HW  = 6;
    localparam int NUM_SRC = NUM_HW + 2;
    localparam int SEL_W   = $clog2(NUM_SRC);
    localparam int ADDR_W  = 16;
    localparam int STAT_W  = 16;

    localparam logic [SEL_W-1:0] SEL_RESET = '0;
    localparam logic [SEL_W-1:0] SEL_SWI   = SEL_W'(1);

    // Control bits that disable their source when set
    localparam logic [NUM_HW-1:0] CTRL_ACTIVE_LOW = 6'b010001;

    typedef logic [ADDR_W-1:0] addr_t;

    // Vector address for each source index
    function automatic addr_t vector_of(input logic [SEL_W-1:0] idx);
        case (idx)
            3'd0:    return 16'hFFFE;
            3'd1:    return 16'hFFFC;
            3'd2:    return 16'hFFFA;
            3'd3:    return 16'hFFF6;
            3'd4:    return 16'hFFF4;
            3'd5:    return 16'hFFF2;
            3'd6:    return 16'hFFE0;
            default: return 16'hFFDE;
        endcase
    endfunction

    // Status-word bit position for each hardware flag
    function automatic int status_pos(input int hw);
        case (hw)
            0:       return 1;
            1:       return 3;
            2:       return 4;
            3:       return 5;
            4:       return 14;
            default: return 15;
        endcase
    endfunction
endpackage

// File: rtl/irqv_gate.sv
// Module irqv_gate: qualifies each hardware flag with its local control bit
// (per-bit polarity from a parameter) and with the global mask.
// Assumes all inputs are synchronous to the consumer's clock.
module irqv_gate #(
    parameter int                NUM_HW     = 6,
    parameter logic [NUM_HW-1:0] ACTIVE_LOW = '0
) (
    input  logic [NUM_HW-1:0] flag,
    input  logic [NUM_HW-1:0] ctrl,
    input  logic              gmask,
    output logic [NUM_HW-1:0] req
);
    for (genvar g = 0; g < NUM_HW; g++) begin : g_src
        logic en;
        if (ACTIVE_LOW[g]) begin : g_low
            assign en = ~ctrl[g];   // control bit set means disabled
        end else begin : g_high
            assign en = ctrl[g];    // control bit set means enabled
        end
        assign req[g] = flag[g] & en & ~gmask;
    end
endmodule

// File: rtl/irqv_prio.sv
// Module irqv_prio: fixed-priority encoder, lowest index wins.
// Assumes req is a plain level vector; result is combinational.
module irqv_prio #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from lowest priority upward so the lowest index overrides
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqv_status.sv
// Module irqv_status: scatters raw hardware flags into a sparse status word.
// Positions come from the package; unused bits are tied to zero.
module irqv_status
    import irqv_pkg::*;
(
    input  logic [NUM_HW-1:0] flag,
    output logic [STAT_W-1:0] status
);
    logic [NUM_HW-1:0][STAT_W-1:0] part;

    for (genvar g = 0; g < NUM_HW; g++) begin : g_map
        assign part[g] = STAT_W'(flag[g]) << status_pos(g);
    end

    // Merge all placed flags
    always_comb begin
        status = '0;
        for (int i = 0; i < NUM_HW; i++) status = status | part[i];
    end
endmodule

// File: rtl/irqv_top.sv
// Module irqv_top: interrupt arbiter and vector holder.
// Arbitrates at instruction boundaries, holds the winner until ack,
// owns the global mask and latches software requests.
// Assumes ack arrives only while take_valid is high.
module irqv_top
    import irqv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_req,
    input  logic              swi_req,
    input  logic [5:0]        hw_flag,
    input  logic [5:0]        hw_ctrl,
    input  logic              cli,
    input  logic              boundary,
    input  logic [15:0]       pc,
    input  logic              ack,
    output logic              take_valid,
    output logic [15:0]       vector,
    output logic [15:0]       ret_addr,
    output logic              i_mask,
    output logic [15:0]       status
);
    logic [NUM_HW-1:0]  hw_req;
    logic [NUM_SRC-1:0] all_req;
    logic               found;
    logic [SEL_W-1:0]   win;
    logic [SEL_W-1:0]   sel_q;
    logic               swi_pend;
    logic               swi_live;
    logic               done;

    assign swi_live = swi_pend | swi_req;
    assign done     = take_valid & ack;
    assign all_req  = {hw_req, swi_live, reset_req};

    irqv_gate #(.NUM_HW(NUM_HW), .ACTIVE_LOW(CTRL_ACTIVE_LOW)) u_gate (
        .flag(hw_flag), .ctrl(hw_ctrl), .gmask(i_mask), .req(hw_req)
    );

    irqv_prio #(.N(NUM_SRC), .IDX_W(SEL_W)) u_prio (
        .req(all_req), .found(found), .idx(win)
    );

    irqv_status u_status (.flag(hw_flag), .status(status));

    // Remember software requests until their vector is acknowledged
    always_ff @(posedge clk) begin
        if (!rst_n)
            swi_pend <= 1'b0;
        else
            swi_pend <= swi_req | (swi_pend & ~(done & (sel_q == SEL_SWI)));
    end

    // Arbitration, hold and global-mask control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_valid <= 1'b0;
            sel_q      <= SEL_RESET;
            vector     <= '0;
            ret_addr   <= '0;
            i_mask     <= 1'b1;
        end else if (reset_req) begin
            take_valid <= 1'b1;
            sel_q      <= SEL_RESET;
            vector     <= vector_of(SEL_RESET);
            ret_addr   <= '0;
            i_mask     <= 1'b1;
        end else begin
            if (done && sel_q != SEL_RESET) i_mask <= 1'b1;
            else if (cli)                   i_mask <= 1'b0;

            if (done) begin
                take_valid <= 1'b0;
            end else if (!take_valid && boundary && found) begin
                take_valid <= 1'b1;
                sel_q      <= win;
                vector     <= vector_of(win);
                ret_addr   <= (win == SEL_SWI) ? pc : pc - 16'd1;
            end
        end
    end

    // R1: reset request always yields the reset vector with mask set
    a_r1_reset_taken: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (take_valid && vector == 16'hFFFE && i_mask));

    // R7: held results do not move until acknowledged
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (take_valid && !ack && !reset_req) |=>
            (take_valid && $stable(vector) && $stable(ret_addr)));

    // R7: no take without a boundary
    a_r7_no_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_valid && !boundary && !reset_req) |=> !take_valid);

    // R8: acknowledging a non-reset interrupt leaves the mask set
    a_r8_mask_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sel_q != SEL_RESET && !reset_req) |=> i_mask);

    // R4: with mask set and no software or reset request, nothing is taken
    a_r4_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_valid && i_mask && !swi_live && !reset_req) |=> !take_valid);
endmodule

// File: tb/irqv_top_bench.sv
module irqv_top_bench;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, reset_req, swi_req, cli, boundary, ack;
    logic [5:0]  hw_flag, hw_ctrl;
    logic [15:0] pc;
    logic        take_valid, i_mask;
    logic [15:0] vector, ret_addr, status;

    int   n_run = 0, n_fail = 0;
    bit   auto_ack = 1'b1;
    bit   finished = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [5:0] ALL_ON = 6'b101110;  // every source enabled

    always #(PERIOD/2) clk = ~clk;

    irqv_top u_irqv_top (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .swi_req(swi_req),
        .hw_flag(hw_flag), .hw_ctrl(hw_ctrl), .cli(cli), .boundary(boundary),
        .pc(pc), .ack(ack), .take_valid(take_valid), .vector(vector),
        .ret_addr(ret_addr), .i_mask(i_mask), .status(status)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected vector/return pair and acknowledges
    always @(negedge clk) begin
        if (rst_n && auto_ack && take_valid && !ack) begin
            if (exp_q.size() == 0) begin
                chk("R7 unexpected take", {vector, ret_addr}, 32'h0);
            end else begin
                chk(tag_q.pop_front(), {vector, ret_addr}, exp_q.pop_front());
            end
            ack = 1'b1;
        end else begin
            ack = 1'b0;
        end
    end

    task automatic pulse_cli();
        @(negedge clk) cli = 1'b1;
        @(negedge clk) cli = 1'b0;
    endtask

    task automatic pulse_swi();
        @(negedge clk) swi_req = 1'b1;
        @(negedge clk) swi_req = 1'b0;
    endtask

    // Driver: queue the expectation and strobe a boundary
    task automatic arb(input logic [15:0] v, input logic [15:0] r, input string tag);
        exp_q.push_back({v, r});
        tag_q.push_back(tag);
        @(negedge clk) boundary = 1'b1;
        @(negedge clk) boundary = 1'b0;
        repeat (3) @(negedge clk);
        chk({tag, " drained"}, exp_q.size(), 0);
    endtask

    task automatic arb_none(input string tag);
        @(negedge clk) boundary = 1'b1;
        @(negedge clk) boundary = 1'b0;
        @(negedge clk);
        chk(tag, take_valid, 1'b0);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; reset_req = 0; swi_req = 0; cli = 0; boundary = 0; ack = 0;
        hw_flag = '0; hw_ctrl = ALL_ON; pc = 16'h1234;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R11 take_valid", take_valid, 1'b0);
        chk("R11 i_mask", i_mask, 1'b1);

        // R4: mask blocks hardware, not software
        hw_flag = 6'b000001;
        arb_none("R4 masked pin");
        pulse_swi();
        arb(16'hFFFC, 16'h1234, "R4/R5 swi under mask");
        chk("R8 mask after swi", i_mask, 1'b1);
        pulse_cli();
        chk("R8 cli clears", i_mask, 1'b0);
        arb(16'hFFFA, 16'h1233, "R3/R5 pin");
        chk("R8 mask after pin", i_mask, 1'b1);

        // R6: local control polarity
        hw_ctrl = 6'b101111; pulse_cli();
        arb_none("R6 pin disabled by 1");
        hw_ctrl = ALL_ON;
        arb(16'hFFFA, 16'h1233, "R6 pin enabled by 0");
        hw_flag = 6'b010000; hw_ctrl = 6'b111110; pulse_cli();
        arb_none("R6 keyboard disabled by 1");
        hw_ctrl = ALL_ON;
        arb(16'hFFE0, 16'h1233, "R6 keyboard enabled by 0");
        hw_flag = 6'b000010; hw_ctrl = 6'b101100; pulse_cli();
        arb_none("R6 ch0 disabled by 0");
        hw_ctrl = ALL_ON;
        arb(16'hFFF6, 16'h1233, "R6 ch0 enabled by 1");

        // R2/R10: full priority chain
        hw_flag = 6'b111111; pulse_swi();
        arb(16'hFFFC, 16'h1234, "R2 swi over all");
        pulse_cli(); arb(16'hFFFA, 16'h1233, "R2/R10 pin");
        hw_flag = 6'b111110; pulse_cli(); arb(16'hFFF6, 16'h1233, "R2/R10 ch0");
        hw_flag = 6'b111100; pulse_cli(); arb(16'hFFF4, 16'h1233, "R2/R10 ch1");
        hw_flag = 6'b111000; pulse_cli(); arb(16'hFFF2, 16'h1233, "R2/R10 overflow");
        hw_flag = 6'b110000; pulse_cli(); arb(16'hFFE0, 16'h1233, "R2/R10 keyboard");
        hw_flag = 6'b100000; pulse_cli(); arb(16'hFFDE, 16'h1233, "R2/R10 conversion");

        // R7: hold until ack despite new pc, flags and boundaries
        hw_flag = 6'b000001; pulse_cli();
        auto_ack = 1'b0;
        @(negedge clk) boundary = 1'b1;
        @(negedge clk) boundary = 1'b0; pc = 16'hABCD; hw_flag = 6'b100000;
        @(negedge clk) boundary = 1'b1;
        @(negedge clk) boundary = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 held valid", take_valid, 1'b1);
        chk("R7 held vector", vector, 16'hFFFA);
        chk("R7 held ret", ret_addr, 16'h1233);
        exp_q.push_back({16'hFFFA, 16'h1233}); tag_q.push_back("R7 release");
        auto_ack = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 drained", exp_q.size(), 0);
        pc = 16'h1234; hw_flag = '0;

        // R1: reset request overrides a held vector
        pulse_cli();
        hw_flag = 6'b000001;
        auto_ack = 1'b0;
        @(negedge clk) boundary = 1'b1;
        @(negedge clk) boundary = 1'b0;
        chk("R1 pin held first", vector, 16'hFFFA);
        hw_flag = '0;
        @(negedge clk) reset_req = 1'b1;
        @(negedge clk) reset_req = 1'b0;
        chk("R1 reset vector", vector, 16'hFFFE);
        chk("R1 reset ret", ret_addr, 16'h0000);
        chk("R1 mask set", i_mask, 1'b1);
        exp_q.push_back({16'hFFFE, 16'h0000}); tag_q.push_back("R1 reset ack");
        auto_ack = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 drained", exp_q.size(), 0);

        // R9: status word placement
        hw_flag = 6'b101010; @(negedge clk);
        chk("R9 status a", status, 16'h8028);
        hw_flag = 6'b010101; @(negedge clk);
        chk("R9 status b", status, 16'h4012);
        hw_flag = 6'b000000; @(negedge clk);
        chk("R9 status zero", status, 16'h0000);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule